// File: doc/BRIEF.md
# Edge-Triggered Capture Timer

This block measures a pulse-width-modulated signal in one pass. A single external event line is brought into the clock domain, and its edges both start and stop an internal up-counter. The same edges load snapshots of the counter. One snapshot register is loaded by rising edges and the other by falling edges. When the counter has been started by one rising edge and stopped by the next, the rising-edge register holds the period and the falling-edge register holds the high time. Both values are one less than the number of clock cycles.

The block only responds when its mode field selects capture operation and its trigger gate is open. Separate enables decide whether an edge may start the counter, whether an edge may stop it, and whether a stop raises an interrupt pulse. The counter is 16 bits wide by default. It does not wrap: it stays at all ones and sets a flag that is only cleared by the next start or by reset.

Top module: `edge_capture_timer`

## Requirements
- R1: Edges of the event input act only when `mode_sel` equals 2'b01. With any other mode value they change neither the counter nor either capture register.
- R2: While `trig_en` is low, edges of the event input change neither the counter nor either capture register.
- R3: The event input passes through two synchronizing flops and an edge detector. An edge driven before clock edge k takes effect at clock edge k+2, so the outputs change after the third rising clock edge.
- R4: When the counter is idle and `start_en` is high, a rising edge starts it. `count` reads 0 after that clock edge and then rises by one per clock.
- R5: A rising edge seen while counting copies the pre-edge `count` into `cap_rise`. The rising edge that starts the counter does not load `cap_rise`.
- R6: Every falling edge that passes the gates of R1 and R2 copies the current `count` into `cap_fall`.
- R7: With `stop_en` high, a rising edge seen while counting stops the counter, and `count` then holds its value. With `stop_en` low, the counter keeps counting through such an edge.
- R8: A stop by R7 produces a `stop_irq` pulse exactly one clock wide, aligned with the stop, and only when `irq_en` is high.
- R9: The counter stops at 16'hFFFF instead of wrapping. The first attempted increment past that value sets `overflow`. `overflow` stays set until the next start or reset.
- R10: For an input with a period of P clocks and a high time of H clocks, a start-and-stop sequence leaves `cap_rise` = P-1 and `cap_fall` = H-1.
- R11: After reset, `count`, `cap_rise`, `cap_fall`, `overflow` and `stop_irq` are all zero and the counter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | Asynchronous event input |
| mode_sel | input | 2 | Mode field; 2'b01 selects capture |
| trig_en | input | 1 | Master gate for event edges |
| start_en | input | 1 | Allow a rising edge to start the counter |
| stop_en | input | 1 | Allow a rising edge to stop the counter |
| irq_en | input | 1 | Allow a stop to raise the interrupt pulse |
| cap_rise | output | 16 | Count captured on rising edges |
| cap_fall | output | 16 | Count captured on falling edges |
| count | output | 16 | Live counter value |
| overflow | output | 1 | Sticky saturation flag |
| stop_irq | output | 1 | One-cycle stop interrupt pulse |

## Verification
The stopping rising edge does three things in the same clock: it loads `cap_rise`, it freezes the counter and it raises `stop_irq`. A rising edge with stop disabled makes the capture fall in the same cycle as an ordinary increment instead. The bench drives square waves whose period and high time are known, with the stop enable set both ways. A behavioural reference model fed with the same delayed input samples is compared against all outputs on every clock. Directed checks then confirm the period and high-time values, and confirm that a capture sees the count from before the edge and not from after it.

// File: rtl/ect_pkg.sv
package ect_pkg;

    parameter int unsigned DEF_CNT_W       = 16;
    parameter int unsigned DEF_SYNC_STAGES = 2;

    localparam logic [1:0] MODE_CAPTURE = 2'b01;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    function automatic edge_evt_t gate_events(edge_evt_t raw, logic open);
        edge_evt_t g;
        g.rise = raw.rise & open;
        g.fall = raw.fall & open;
        return g;
    endfunction

endpackage

// File: rtl/ect_edge_sync.sv
module ect_edge_sync
    import ect_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output edge_evt_t evt
);

    localparam int unsigned PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[PIPE_W-2:0], din};
        end
    end

    always_comb begin
        evt.rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
        evt.fall = ~pipe[SYNC_STAGES-1] & pipe[SYNC_STAGES];
    end

    AST_EDGE_ORDER: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> !evt.rise) else $error("double rise"); // R3

endmodule

// File: rtl/ect_run_counter.sv
module ect_run_counter
    import ect_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_rise,
    input  logic             start_en,
    input  logic             stop_en,
    input  logic             irq_en,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             overflow,
    output logic             stop_irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    run_st_e st;
    logic    start_hit;
    logic    stop_hit;
    logic    at_max;

    assign running = (st == ST_RUN);

    always_comb begin
        start_hit = (st == ST_IDLE) && trig_rise && start_en;
        stop_hit  = (st == ST_RUN) && trig_rise && stop_en;
        at_max    = (count == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            count    <= '0;
            overflow <= 1'b0;
            stop_irq <= 1'b0;
        end else begin
            stop_irq <= 1'b0;
            if (start_hit) begin
                st       <= ST_RUN;
                count    <= '0;
                overflow <= 1'b0;
            end else if (stop_hit) begin
                st       <= ST_IDLE;
                stop_irq <= irq_en;
            end else if (st == ST_RUN) begin
                if (at_max) begin
                    overflow <= 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        stop_irq |=> !stop_irq) else $error("irq too wide"); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!running && !(trig_rise && start_en)) |=> $stable(count)) else $error("idle count moved"); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (running && at_max) |=> (count == CNT_MAX)) else $error("counter wrapped"); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !start_hit) |=> overflow) else $error("overflow dropped"); // R9
    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        start_hit |=> (count == '0 && running)) else $error("start not at zero"); // R4

endmodule

// File: rtl/ect_capture_regs.sv
module ect_capture_regs
    import ect_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_evt_t        evt,
    input  logic             running,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_rise,
    output logic [CNT_W-1:0] cap_fall
);

    logic load_rise;

    assign load_rise = evt.rise & running;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_rise <= '0;
            cap_fall <= '0;
        end else begin
            if (load_rise) begin
                cap_rise <= count;
            end
            if (evt.fall) begin
                cap_fall <= count;
            end
        end
    end

    AST_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_rise |=> $stable(cap_rise)) else $error("cap_rise moved"); // R5
    AST_FALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !evt.fall |=> $stable(cap_fall)) else $error("cap_fall moved"); // R6

endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
    import ect_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_in,
    input  logic [1:0]       mode_sel,
    input  logic             trig_en,
    input  logic             start_en,
    input  logic             stop_en,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cap_rise,
    output logic [CNT_W-1:0] cap_fall,
    output logic [CNT_W-1:0] count,
    output logic             overflow,
    output logic             stop_irq
);

    edge_evt_t raw_evt;
    edge_evt_t act_evt;
    logic      gate_open;
    logic      running;

    assign gate_open = trig_en && (mode_sel == MODE_CAPTURE);
    assign act_evt   = gate_events(raw_evt, gate_open);

    ect_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (evt_in),
        .evt (raw_evt)
    );

    ect_run_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .trig_rise (act_evt.rise),
        .start_en  (start_en),
        .stop_en   (stop_en),
        .irq_en    (irq_en),
        .count     (count),
        .running   (running),
        .overflow  (overflow),
        .stop_irq  (stop_irq)
    );

    ect_capture_regs #(
        .CNT_W (CNT_W)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .evt      (act_evt),
        .running  (running),
        .count    (count),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall)
    );

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        !gate_open |=> ($stable(cap_rise) && $stable(cap_fall))) else $error("gate leak"); // R2
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (!irq_en) |=> !stop_irq) else $error("irq without enable"); // R8

endmodule

// File: tb/edge_capture_timer_bench.sv
`timescale 1ns/1ps
module edge_capture_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_in = 1'b0;
    logic [1:0]  mode_sel = 2'b01;
    logic        trig_en = 1'b1;
    logic        start_en = 1'b1;
    logic        stop_en = 1'b1;
    logic        irq_en = 1'b1;
    logic [15:0] cap_rise, cap_fall, count;
    logic        overflow, stop_irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    edge_capture_timer u_edge_capture_timer (
        .clk(clk), .rst(rst), .evt_in(evt_in), .mode_sel(mode_sel),
        .trig_en(trig_en), .start_en(start_en), .stop_en(stop_en), .irq_en(irq_en),
        .cap_rise(cap_rise), .cap_fall(cap_fall), .count(count),
        .overflow(overflow), .stop_irq(stop_irq)
    );

    // behavioural reference model
    bit hist[$] = '{0, 0, 0};
    int m_cnt = 0, m_a = 0, m_b = 0;
    bit m_run = 0, m_ovf = 0, m_irq = 0;

    always @(posedge clk) begin
        bit lvl, prv, gate, r, f;
        cycles++;
        lvl  = hist[hist.size()-2];
        prv  = hist[hist.size()-3];
        hist.push_back(rst ? 1'b0 : evt_in);
        if (hist.size() > 5) void'(hist.pop_front());
        if (rst) begin
            m_cnt = 0; m_a = 0; m_b = 0; m_run = 0; m_ovf = 0; m_irq = 0;
        end else begin
            gate = trig_en && (mode_sel == 2'b01);
            r = gate && lvl && !prv;
            f = gate && !lvl && prv;
            m_irq = 0;
            if (m_run && r) m_a = m_cnt;
            if (f) m_b = m_cnt;
            if (!m_run) begin
                if (r && start_en) begin m_run = 1; m_cnt = 0; m_ovf = 0; end
            end else if (r && stop_en) begin
                m_run = 0; m_irq = irq_en;
            end else if (m_cnt == 65535) m_ovf = 1;
            else m_cnt++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R3/R4 count vs model", count, m_cnt);
            check("R5 cap_rise vs model", cap_rise, m_a);
            check("R6 cap_fall vs model", cap_fall, m_b);
            check("R9 overflow vs model", overflow, m_ovf);
            check("R8 stop_irq vs model", stop_irq, m_irq);
            if (stop_irq) irq_seen++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(2000000 * 1ns);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int snap_a, snap_b, snap_c, irq0;
        cyc(5);
        rst = 1'b0;
        cyc(1);
        check("R11 reset count", count, 0);
        check("R11 reset cap_rise", cap_rise, 0);
        check("R11 reset cap_fall", cap_fall, 0);
        check("R11 reset overflow", overflow, 0);
        check("R11 reset stop_irq", stop_irq, 0);
        cyc(3);

        // R3 latency and R4 start, then R10 period 20 high 7
        evt_in = 1'b1;
        cyc(3);
        check("R3 no count before third edge", count, 0);
        cyc(1);
        check("R4 first increment", count, 1);
        check("R5 start edge does not capture", cap_rise, 0);
        cyc(3);
        evt_in = 1'b0;
        cyc(13);
        irq0 = irq_seen;
        evt_in = 1'b1;
        cyc(4);
        check("R10 period capture", cap_rise, 19);
        check("R10 high-time capture", cap_fall, 6);
        check("R7 count held after stop", count, 19);
        check("R8 one irq pulse", irq_seen - irq0, 1);

        // R10 second pattern: period 33, high 20
        cyc(5); evt_in = 1'b0; cyc(10);
        evt_in = 1'b1; cyc(20);
        evt_in = 1'b0; cyc(13);
        evt_in = 1'b1; cyc(4);
        check("R10 period 33", cap_rise, 32);
        check("R10 high 20", cap_fall, 19);

        // R7 stop disabled: rise while running captures, counting goes on
        stop_en = 1'b0;
        evt_in = 1'b0; cyc(5);
        evt_in = 1'b1; cyc(10);
        evt_in = 1'b0; cyc(10);
        evt_in = 1'b1; cyc(4);
        check("R5 capture while running", cap_rise, 19);
        check("R7 counting continues without stop_en", count, 21);

        // R8 stop with irq disabled
        stop_en = 1'b1; irq_en = 1'b0;
        irq0 = irq_seen;
        evt_in = 1'b0; cyc(5);
        evt_in = 1'b1; cyc(4);
        snap_c = count;
        cyc(3);
        check("R7 count frozen", count, snap_c);
        check("R8 no irq when disabled", irq_seen - irq0, 0);
        irq_en = 1'b1;

        // R2 gate closed
        evt_in = 1'b0; cyc(5);
        trig_en = 1'b0;
        snap_a = cap_rise; snap_b = cap_fall; snap_c = count;
        evt_in = 1'b1; cyc(5); evt_in = 1'b0; cyc(5); evt_in = 1'b1; cyc(5);
        check("R2 count ignored", count, snap_c);
        check("R2 cap_rise ignored", cap_rise, snap_a);
        check("R2 cap_fall ignored", cap_fall, snap_b);
        evt_in = 1'b0; cyc(5);

        // R1 wrong mode
        trig_en = 1'b1; mode_sel = 2'b10;
        evt_in = 1'b1; cyc(5); evt_in = 1'b0; cyc(5); evt_in = 1'b1; cyc(5);
        check("R1 count ignored", count, snap_c);
        check("R1 cap_rise ignored", cap_rise, snap_a);
        check("R1 cap_fall ignored", cap_fall, snap_b);
        evt_in = 1'b0; cyc(5);
        mode_sel = 2'b01;

        // R9 saturation and sticky overflow
        evt_in = 1'b1; cyc(66000);
        check("R9 saturated", count, 65535);
        check("R9 overflow set", overflow, 1);
        evt_in = 1'b0; cyc(5); evt_in = 1'b1; cyc(5);
        check("R9 overflow sticky after stop", overflow, 1);
        check("R9 held at max", count, 65535);
        evt_in = 1'b0; cyc(5); evt_in = 1'b1; cyc(4);
        check("R9 overflow cleared on start", overflow, 0);
        check("R4 restart from zero", count, 1);

        cyc(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule